// File: doc/BRIEF.md
# Smart Card Power-Down Sequencer

This block shuts down a contact smart card in a fixed, timed order after the host ends a session. The host holds an active-low session command low while the card is in use. When that command returns high, the block starts counting system clock cycles. At set offsets it pulls card reset low, stops the card clock, forces the data and auxiliary lines low, and then removes the card supply and the boost supply. Every offset is a fraction of a timing unit `T_UNIT`, given in system clock cycles.

The sequence finishes only once two things are true: the boost-supply step has passed, and the supply-sensing logic reports, through one digital input, that the card supply has dropped below its threshold. At that point the card contacts are tied to ground and the oscillator select asks for the low-frequency mode. The inactive flag then stays set until the host requests a new session.

The activation sequence is outside this block. A new session request hands the card outputs back at their active levels. The card clock comes from outside, already divided and synchronous to `clk_i`. This block only gates it. `T_UNIT` must be a multiple of 64.

Top module: `card_deact_seq`

## Requirements
- R1: While `rst_ni` is low, and afterwards until a session is requested, the outputs are: `inactive_o`, `contacts_gnd_o`, `osc_low_o` and `card_io_low_o` at 1; `card_rst_o`, `card_vcc_en_o`, `card_vup_en_o`, `card_clk_o` and `done_o` at 0. Reset acts at once, including in the middle of a sequence.
- R2: If `sess_n_i` is sampled low while the block is inactive, then from the next clock edge onward: `card_rst_o`, `card_vcc_en_o` and `card_vup_en_o` are 1, and `card_io_low_o`, `contacts_gnd_o`, `osc_low_o` and `inactive_o` are 0. While the session is active, `sup_low_i` has no effect.
- R3: Cycle 0 is the first clock edge that samples `sess_n_i` high in an active session. Cycle k is the k-th edge after it. `card_rst_o` falls after cycle P_RST = 3·T_UNIT/64.
- R4: After cycle P_RST + T_UNIT/2, `card_clk_o` stops in its low state. The gate opens and closes only while `card_clk_i` is low. As a result, `card_clk_o` is high only while `card_clk_i` is high, and every high pulse it passes is a full card-clock high phase.
- R5: `card_io_low_o` rises after cycle P_RST + T_UNIT.
- R6: `card_vcc_en_o` falls after cycle P_RST + 3·T_UNIT/2.
- R7: `card_vup_en_o` falls after cycle P_RST + 7·T_UNIT/2 (P_VUP).
- R8: The block becomes inactive at the first edge, no earlier than cycle P_VUP+1, that samples `sup_low_i` high. Until then it stays in the power-down state with every step output held.
- R9: When the sequence completes, `contacts_gnd_o`, `osc_low_o`, `inactive_o` and `card_io_low_o` go to 1 together, and `done_o` is high for exactly that one cycle.
- R10: If `sess_n_i` goes low during power-down, the step timing and the completion do not change. The block is inactive for at least one cycle before the new session starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sess_n_i | input | 1 | Session command from the host, active low |
| sup_low_i | input | 1 | Card supply is below its threshold |
| card_clk_i | input | 1 | Divided card clock, synchronous to clk_i |
| card_rst_o | output | 1 | Card reset level (1 = released) |
| card_clk_o | output | 1 | Gated card clock |
| card_io_low_o | output | 1 | Force the I/O and auxiliary lines low |
| card_vcc_en_o | output | 1 | Card supply enable |
| card_vup_en_o | output | 1 | Boost supply enable |
| contacts_gnd_o | output | 1 | Card contacts low-impedance to ground |
| osc_low_o | output | 1 | Select the low-frequency internal oscillator |
| inactive_o | output | 1 | Card is inactive |
| done_o | output | 1 | Single-cycle pulse when power-down completes |

## Verification
The bench builds the block with `T_UNIT` = 128. With that value the step offsets are cycles 6, 70, 134, 198 and 454, so each full sequence runs in a few hundred cycles. The bench compares every output on every cycle of each sequence. The card clock runs at one sixth of the system clock. This makes the stop request land partway through a card-clock high phase, so the deferred gating is exercised. The bench also raises the supply-low input both before and well after the last step, and it pulls the host command low partway through a sequence.

// File: rtl/cds_pkg.sv
package cds_pkg;

  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_ON   = 2'd1,
    ST_DOWN = 2'd2
  } cds_state_e;

  localparam int N_STEP = 5;

  // step index: 0 reset, 1 clock stop, 2 line pull-down, 3 supply off, 4 boost off
  function automatic int step_at(input int t_unit, input int idx);
    int base;
    base = (3 * t_unit) / 64;
    case (idx)
      0:       return base;
      1:       return base + t_unit / 2;
      2:       return base + t_unit;
      3:       return base + (3 * t_unit) / 2;
      default: return base + (7 * t_unit) / 2;
    endcase
  endfunction

endpackage

// File: rtl/cds_phase_cnt.sv
module cds_phase_cnt
  import cds_pkg::*;
#(
  parameter int T_UNIT = 2048
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  output logic [N_STEP-1:0] reach_o
);

  localparam int LAST = step_at(T_UNIT, N_STEP - 1);
  localparam int CW   = $clog2(LAST + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i)            cnt_q <= '0;
    else if (cnt_q != CW'(LAST)) cnt_q <= cnt_q + CW'(1);
  end

  for (genvar g = 0; g < N_STEP; g++) begin : g_step
    localparam int THR = step_at(T_UNIT, g);
    assign reach_o[g] = (cnt_q >= CW'(THR));
  end

  a_r3_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(LAST));

  a_r3_cnt_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (cnt_q == '0));

endmodule

// File: rtl/cds_clk_gate.sv
module cds_clk_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic card_clk_i,
  input  logic run_i,
  output logic card_clk_o
);

  logic gate_q;

  // gate state only moves during the card clock low phase
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          gate_q <= 1'b0;
    else if (!card_clk_i) gate_q <= run_i;
  end

  assign card_clk_o = card_clk_i & gate_q;

  a_r4_gate_in_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_q != $past(gate_q)) |-> !$past(card_clk_i));

  a_r4_no_runt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(card_clk_o) |-> $fell(card_clk_i));

endmodule

// File: rtl/cds_ctrl.sv
module cds_ctrl
  import cds_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sess_n_i,
  input  logic       sup_low_i,
  input  logic       last_i,
  output cds_state_e state_o,
  output logic       done_o
);

  cds_state_e state_q, state_d;
  logic       done_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_OFF:  if (!sess_n_i)            state_d = ST_ON;
      ST_ON:   if (sess_n_i)             state_d = ST_DOWN;
      ST_DOWN: if (last_i && sup_low_i)  state_d = ST_OFF;
      default:                           state_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_OFF;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= (state_q == ST_DOWN) && (state_d == ST_OFF);
    end
  end

  assign state_o = state_q;
  assign done_o  = done_q;

  a_r8_exit_needs_supply: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_OFF) && ($past(state_q) == ST_DOWN)) |-> ($past(sup_low_i) && $past(last_i)));

  a_r10_no_abort: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state_q) == ST_DOWN) |-> (state_q != ST_ON));

  a_r9_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r9_done_inactive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (state_q == ST_OFF));

endmodule

// File: rtl/card_deact_seq.sv
module card_deact_seq
  import cds_pkg::*;
#(
  parameter int T_UNIT = 2048
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sess_n_i,
  input  logic sup_low_i,
  input  logic card_clk_i,
  output logic card_rst_o,
  output logic card_clk_o,
  output logic card_io_low_o,
  output logic card_vcc_en_o,
  output logic card_vup_en_o,
  output logic contacts_gnd_o,
  output logic osc_low_o,
  output logic inactive_o,
  output logic done_o
);

  localparam int S_RST = 0;
  localparam int S_CLK = 1;
  localparam int S_IO  = 2;
  localparam int S_VCC = 3;
  localparam int S_VUP = 4;

  cds_state_e        state;
  logic [N_STEP-1:0] reach;
  logic              on, down, off, clk_run;

  cds_ctrl i_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sess_n_i  (sess_n_i),
    .sup_low_i (sup_low_i),
    .last_i    (reach[S_VUP]),
    .state_o   (state),
    .done_o    (done_o)
  );

  cds_phase_cnt #(.T_UNIT(T_UNIT)) i_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (down),
    .reach_o (reach)
  );

  cds_clk_gate i_gate (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .card_clk_i (card_clk_i),
    .run_i      (clk_run),
    .card_clk_o (card_clk_o)
  );

  assign on   = (state == ST_ON);
  assign down = (state == ST_DOWN);
  assign off  = (state == ST_OFF);

  assign clk_run        = on | (down & ~reach[S_CLK]);
  assign card_rst_o     = on | (down & ~reach[S_RST]);
  assign card_io_low_o  = off | (down & reach[S_IO]);
  assign card_vcc_en_o  = on | (down & ~reach[S_VCC]);
  assign card_vup_en_o  = on | (down & ~reach[S_VUP]);
  assign contacts_gnd_o = off;
  assign osc_low_o      = off;
  assign inactive_o     = off;

  a_r6_vcc_needs_vup: assert property (@(posedge clk_i) disable iff (!rst_ni)
    card_vcc_en_o |-> card_vup_en_o);

  a_r3_rst_needs_vcc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    card_rst_o |-> card_vcc_en_o);

  a_r9_gnd_with_lines_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    contacts_gnd_o |-> (card_io_low_o && !card_vcc_en_o));

endmodule

// File: tb/test_card_deact_seq.sv
`timescale 1ns/1ps
module test_card_deact_seq;

  localparam int TB_T  = 128;
  localparam int P_RST = (3 * TB_T) / 64;
  localparam int P_CLK = P_RST + TB_T / 2;
  localparam int P_IO  = P_RST + TB_T;
  localparam int P_VCC = P_RST + (3 * TB_T) / 2;
  localparam int P_VUP = P_RST + (7 * TB_T) / 2;
  localparam int HALF  = 3;

  // {rst, io_low, vcc, vup, gnd, osc_low, inactive, done}
  localparam logic [7:0] V_OFF      = 8'b0100_1110;
  localparam logic [7:0] V_OFF_DONE = 8'b0100_1111;
  localparam logic [7:0] V_ON       = 8'b1011_0000;

  logic clk = 1'b0;
  logic rst_ni, sess_n, sup_low, card_clk;
  logic card_rst, card_clk_o, io_low, vcc_en, vup_en, gnd, osc_low, inactive, done;
  int   n_chk = 0;
  int   n_bad = 0;
  bit   finished = 0;

  always #2.5 clk = ~clk;

  card_deact_seq #(.T_UNIT(TB_T)) i_card_deact_seq (
    .clk_i          (clk),
    .rst_ni         (rst_ni),
    .sess_n_i       (sess_n),
    .sup_low_i      (sup_low),
    .card_clk_i     (card_clk),
    .card_rst_o     (card_rst),
    .card_clk_o     (card_clk_o),
    .card_io_low_o  (io_low),
    .card_vcc_en_o  (vcc_en),
    .card_vup_en_o  (vup_en),
    .contacts_gnd_o (gnd),
    .osc_low_o      (osc_low),
    .inactive_o     (inactive),
    .done_o         (done)
  );

  function automatic logic [7:0] outs();
    return {card_rst, io_low, vcc_en, vup_en, gnd, osc_low, inactive, done};
  endfunction

  function automatic string req_of(input logic [7:0] d);
    if (d[7]) return "R3";
    if (d[6]) return "R5";
    if (d[5]) return "R6";
    if (d[4]) return "R7";
    if (d[1]) return "R8";
    return "R9";
  endfunction

  task automatic check_vec(input string tag, input logic [7:0] exp, input string where);
    logic [7:0] act;
    act = outs();
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b", (tag == "") ? req_of(act ^ exp) : tag,
               where, act, exp);
    end
  endtask

  task automatic check_bit(input string tag, input logic act, input logic exp, input string where);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b", tag, where, act, exp);
    end
  endtask

  // card clock: 3 system cycles high, 3 low
  initial begin
    card_clk = 1'b0;
    forever begin
      repeat (HALF) @(posedge clk);
      card_clk <= ~card_clk;
    end
  end

  // R4: every high pulse passed to the card is a full phase, never outside card_clk high
  initial begin
    int run;
    run = 0;
    forever begin
      @(negedge clk);
      if (card_clk_o && !card_clk) check_bit("R4", card_clk_o, 1'b0, "gated clock high in low phase");
      if (card_clk_o) run++;
      else if (run > 0) begin
        n_chk++;
        if (run != HALF) begin
          n_bad++;
          $display("FAIL R4 card clock pulse length: actual %0d expected %0d", run, HALF);
        end
        run = 0;
      end
    end
  end

  task automatic t_reset();
    rst_ni = 1'b0; sess_n = 1'b1; sup_low = 1'b0;
    repeat (3) @(negedge clk);
    check_vec("R1", V_OFF, "during reset");
    check_bit("R1", card_clk_o, 1'b0, "card clock in reset");
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    check_vec("R1", V_OFF, "idle after reset");
  endtask

  task automatic t_activate();
    @(negedge clk);
    sess_n = 1'b0; sup_low = 1'b1;
    @(posedge clk); @(negedge clk);
    check_vec("R2", V_ON, "one edge after request");
    repeat (20) @(negedge clk);
    check_vec("R2", V_ON, "supply-low ignored while active");
    sup_low = 1'b0;
  endtask

  // sup_at: cycle index after whose check supply-low rises (-1: from the start)
  // drop_at: cycle index after whose check the command goes low (-1: never)
  task automatic t_down(input string tag, input int sup_at, input int drop_at);
    int done_i;
    logic [7:0] exp;
    done_i = (sup_at + 1 > P_VUP + 1) ? sup_at + 1 : P_VUP + 1;
    @(negedge clk);
    sess_n = 1'b1;
    sup_low = (sup_at < 0);
    for (int i = 0; i <= done_i + 1; i++) begin
      @(posedge clk); @(negedge clk);
      if (i < done_i)
        exp = {(i < P_RST), (i >= P_IO), (i < P_VCC), (i < P_VUP), 4'b0000};
      else if (i == done_i)
        exp = V_OFF_DONE;
      else
        exp = (drop_at >= 0) ? V_ON : V_OFF;
      check_vec(tag, exp, $sformatf("cycle %0d", i));
      if (i < P_CLK) check_bit("R4", card_clk_o, card_clk, $sformatf("clock runs, cycle %0d", i));
      else if (i >= P_CLK + 2 * HALF + 1 && i <= done_i)
        check_bit("R4", card_clk_o, 1'b0, $sformatf("clock stopped, cycle %0d", i));
      if (i == sup_at)  sup_low = 1'b1;
      if (i == drop_at) sess_n = 1'b0;
    end
    sup_low = 1'b0;
  endtask

  task automatic t_reset_mid();
    t_activate();
    @(negedge clk);
    sess_n = 1'b1;
    repeat (P_CLK + 30) @(negedge clk);
    rst_ni = 1'b0;
    #1;
    check_vec("R1", V_OFF, "reset mid-sequence");
    @(negedge clk);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    check_vec("R1", V_OFF, "idle after mid reset");
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: actual not finished, expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_activate();
    t_down("", -1, -1);              // R7 R8 R9 supply already low
    t_activate();
    t_down("", P_VUP + 20, -1);      // R8 late supply-low
    t_activate();
    t_down("R10", -1, 100);          // R10 command drop ignored
    repeat (10) @(negedge clk);
    check_vec("R10", V_ON, "new session after completion");
    t_reset_mid();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule